// File: doc/BRIEF.md
# Subcarrier Genlock Serial Transmitter

This block keeps a colour-subcarrier phase accumulator that advances by a 23-bit frequency control word on every pixel clock. Once per scan line, on a line-start strobe, it sends that control word out on one serial pin. A downstream encoder can then steer its own colour oscillator to match. Each transmission opens with a high start bit, sends the word MSB first, waits through a low gap, and ends with a reset slot.

The reset slot is normally high. A phase-reset request pulse is held pending until the next accepted line start. That line then drives its reset slot low. In the first cycle of that low slot the local accumulator is forced to zero, so the phases on both sides of the link restart together.

Two framings are available, and the mode is captured at each line start. The full-rate framing sends one bit per clock. The real-time-control framing runs on a unit of four clocks, holds each bit for two units, drops the least significant word bit, and uses a shorter gap counted in units.

Top module: `sc_genlock_tx`

## Requirements
- R1: While reset is held, the serial pin is low and the phase output is zero on the cycle after each reset edge.
- R2: The pin idles low. When a line strobe is accepted in idle, the pin is high for one bit cell, starting in the cycle after the strobe edge. After the reset slot the pin returns low.
- R3: In full-rate mode (mode_rtc = 0), the 23 word bits follow the start bit, MSB first, one per clock. They are taken from the word captured at the accepted strobe.
- R4: In full-rate mode, the pin is low for 7 clocks after the last word bit. The 1-clock reset slot follows, and it is high when no reset is due.
- R5: In real-time-control mode (mode_rtc = 1), word bits 22 down to 1 are sent MSB first. Each bit lasts 8 clocks (two units of four clocks), and the start bit also lasts 8 clocks.
- R6: In real-time-control mode, the pin is low for 24 clocks (six units) after the last word bit. The reset slot then lasts 8 clocks.
- R7: A request pulse never affects the line already in progress. It makes the reset slot of the next accepted line low, and it is cleared once that slot has been sent.
- R8: Outside a forced reset, the phase output advances each clock by the control word present at that clock edge, modulo 2^23.
- R9: In the first cycle of a low reset slot, the phase output is zero, and it accumulates from zero after that.
- R10: A line strobe that arrives while a transmission is in progress is ignored. It neither restarts the frame nor starts a new one afterwards.
- R11: The mode and the word are sampled only at the accepted strobe. Changes during a line do not alter that line's bits or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_strobe | input | 1 | One-cycle line-start pulse |
| mode_rtc | input | 1 | 0 = full-rate framing, 1 = real-time-control framing |
| ctrl_word | input | 23 | Subcarrier frequency control word |
| phase_rst_req | input | 1 | One-cycle phase-reset request |
| ser_out | output | 1 | Serial genlock pin |
| dds_phase | output | 23 | Accumulator phase |

## Verification
The hardest situation to reach is a request that lands while a frame is in flight. It must leave that frame's slot high, drive the following frame's slot low, and zero the phase in exactly that cycle. The stimulus reaches it by pulsing the request a few clocks into a line. It then runs the next line in the other framing, so the deferred zeroing is also seen at the 8-clock slot timing. The bench's phase model zeroes itself from its own expected slot position. Any disagreement about where the slot falls therefore shows up as a phase mismatch on every cycle that follows.

// File: rtl/sc_gl_pkg.sv
// Shared types for the subcarrier genlock transmitter.
// Assumes: nothing beyond the standard language.
package sc_gl_pkg;

    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_RTC  = 1'b1
    } gl_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_GAP,
        ST_SLOT
    } gl_state_e;

endpackage

// File: rtl/sc_gl_rate.sv
// Unit-tick generator. It emits a tick every clock in full-rate mode and
// every DIV clocks in the slow mode.
// Assumes: DIV >= 2. Restart realigns the divider to a line start.
module sc_gl_rate #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic slow,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Free-running divider, realigned on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // Tick select per mode.
    always_comb tick = slow ? (cnt == LAST) : 1'b1;
endmodule

// File: rtl/sc_gl_dds.sv
// Subcarrier phase accumulator. It adds the frequency word every clock and
// is forced to zero on request.
// Assumes: the zero request is a single-cycle pulse from the framer.
module sc_gl_dds #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         zero,
    input  logic [W-1:0] fcw,
    output logic [W-1:0] phase
);
    // Accumulate modulo 2^W, or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || zero) phase <= '0;
        else                phase <= phase + fcw;
    end
endmodule

// File: rtl/sc_gl_framer.sv
// Per-line serial framer. It sends start bit, word, gap and reset slot,
// with cell lengths chosen by the mode captured at the line strobe.
// Assumes: a unit tick from sc_gl_rate that is realigned at accept.
module sc_gl_framer
    import sc_gl_pkg::*;
#(
    parameter int FCW_W     = 23,
    parameter int RTC_DROP  = 1,
    parameter int RTC_BITU  = 2,
    parameter int FULL_GAP  = 7,
    parameter int RTC_GAP   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line_strobe,
    input  logic             mode_rtc,
    input  logic [FCW_W-1:0] ctrl_word,
    input  logic             phase_rst_req,
    output logic             ser_out,
    output logic             busy,
    output logic             accept,
    output logic             zero_evt,
    output gl_mode_e         mode_q
);
    localparam int RTC_BITS = FCW_W - RTC_DROP;
    localparam int MAXU     = (FULL_GAP > RTC_GAP) ?
                              ((FULL_GAP > RTC_BITU) ? FULL_GAP : RTC_BITU) :
                              ((RTC_GAP > RTC_BITU) ? RTC_GAP : RTC_BITU);
    localparam int UCW      = $clog2(MAXU + 1);
    localparam int BCW      = $clog2(FCW_W + 1);
    localparam logic [BCW-1:0] FULL_LASTB = BCW'(FCW_W - 1);
    localparam logic [BCW-1:0] RTC_LASTB  = BCW'(RTC_BITS - 1);

    gl_state_e        state;
    logic [UCW-1:0]   ucnt;
    logic [BCW-1:0]   bcnt;
    logic [FCW_W-1:0] shreg;
    logic             pending;
    logic             armed;
    logic [UCW-1:0]   cell_last;
    logic [BCW-1:0]   bit_last;
    logic             cell_end;

    // Line acceptance and activity.
    always_comb begin
        busy   = (state != ST_IDLE);
        accept = (state == ST_IDLE) && line_strobe;
    end

    // Last unit index of the current cell and last data bit index.
    always_comb begin
        bit_last = (mode_q == MODE_RTC) ? RTC_LASTB : FULL_LASTB;
        unique case (state)
            ST_GAP:  cell_last = (mode_q == MODE_RTC) ? UCW'(RTC_GAP - 1)
                                                      : UCW'(FULL_GAP - 1);
            default: cell_last = (mode_q == MODE_RTC) ? UCW'(RTC_BITU - 1)
                                                      : '0;
        endcase
        cell_end = busy && tick && (ucnt == cell_last);
        zero_evt = (state == ST_GAP) && cell_end && armed;
    end

    // Frame sequencer: state, unit counter, bit counter and shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ucnt   <= '0;
            bcnt   <= '0;
            shreg  <= '0;
            mode_q <= MODE_FULL;
        end else if (accept) begin
            state  <= ST_START;
            ucnt   <= '0;
            bcnt   <= '0;
            shreg  <= ctrl_word;
            mode_q <= gl_mode_e'(mode_rtc);
        end else if (busy && tick) begin
            if (cell_end) begin
                ucnt <= '0;
                unique case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= {shreg[FCW_W-2:0], 1'b0};
                        bcnt  <= bcnt + 1'b1;
                        if (bcnt == bit_last) state <= ST_GAP;
                    end
                    ST_GAP:  state <= ST_SLOT;
                    default: state <= ST_IDLE;
                endcase
            end else begin
                ucnt <= ucnt + 1'b1;
            end
        end
    end

    // Reset-request bookkeeping: latch, arm at next line, clear after slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            armed   <= 1'b0;
        end else begin
            if (phase_rst_req) pending <= 1'b1;
            else if (accept)   pending <= 1'b0;
            if (accept)                              armed <= pending;
            else if ((state == ST_SLOT) && cell_end) armed <= 1'b0;
        end
    end

    // Pin value per state.
    always_comb begin
        unique case (state)
            ST_START: ser_out = 1'b1;
            ST_DATA:  ser_out = shreg[FCW_W-1];
            ST_SLOT:  ser_out = !armed;
            default:  ser_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/sc_genlock_tx.sv
// Subcarrier genlock serial transmitter top. It ties the rate divider,
// framer and phase accumulator together.
// Assumes: one clock domain, with line strobes at least one frame apart.
module sc_genlock_tx
    import sc_gl_pkg::*;
#(
    parameter int FCW_W    = 23,
    parameter int RTC_DIV  = 4,
    parameter int RTC_DROP = 1,
    parameter int RTC_BITU = 2,
    parameter int FULL_GAP = 7,
    parameter int RTC_GAP  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_strobe,
    input  logic             mode_rtc,
    input  logic [FCW_W-1:0] ctrl_word,
    input  logic             phase_rst_req,
    output logic             ser_out,
    output logic [FCW_W-1:0] dds_phase
);
    logic     fr_tick;
    logic     fr_busy;
    logic     fr_accept;
    logic     fr_zero;
    gl_mode_e fr_mode;
    logic     slow_sel;

    // Slow tick only for the captured slow framing.
    always_comb slow_sel = (fr_mode == MODE_RTC);

    sc_gl_rate #(.DIV(RTC_DIV)) rate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fr_accept),
        .slow    (slow_sel),
        .tick    (fr_tick)
    );

    sc_gl_framer #(
        .FCW_W    (FCW_W),
        .RTC_DROP (RTC_DROP),
        .RTC_BITU (RTC_BITU),
        .FULL_GAP (FULL_GAP),
        .RTC_GAP  (RTC_GAP)
    ) framer_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (fr_tick),
        .line_strobe   (line_strobe),
        .mode_rtc      (mode_rtc),
        .ctrl_word     (ctrl_word),
        .phase_rst_req (phase_rst_req),
        .ser_out       (ser_out),
        .busy          (fr_busy),
        .accept        (fr_accept),
        .zero_evt      (fr_zero),
        .mode_q        (fr_mode)
    );

    sc_gl_dds #(.W(FCW_W)) dds_i (
        .clk   (clk),
        .rst_n (rst_n),
        .zero  (fr_zero),
        .fcw   (ctrl_word),
        .phase (dds_phase)
    );
endmodule

// File: rtl/sc_genlock_tx_chk.sv
// Property checker for sc_genlock_tx, attached by bind.
// Assumes: the internal framer signals of the top are visible by name.
module sc_genlock_tx_chk
    import sc_gl_pkg::*;
#(
    parameter int FCW_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_out,
    input logic [FCW_W-1:0] dds_phase,
    input logic [FCW_W-1:0] ctrl_word,
    input logic             busy,
    input logic             accept,
    input logic             zero_evt,
    input gl_mode_e         mode_q
);
    // R1: reset drives pin low and phase to zero.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!ser_out && dds_phase == '0));

    // R2: an accepted strobe gives a high start bit next cycle.
    a_r2_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ser_out && busy));

    // R8: accumulation by the word seen at each edge.
    a_r8_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(zero_evt)) |->
        dds_phase == FCW_W'($past(dds_phase) + $past(ctrl_word)));

    // R9: phase cleared together with a low reset slot.
    a_r9_zero_phase: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> (dds_phase == '0 && !ser_out));

    // R11: captured mode holds for the whole frame.
    a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && busy && $past(busy)) |-> $stable(mode_q));
endmodule

bind sc_genlock_tx sc_genlock_tx_chk #(.FCW_W(FCW_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_out   (ser_out),
    .dds_phase (dds_phase),
    .ctrl_word (ctrl_word),
    .busy      (fr_busy),
    .accept    (fr_accept),
    .zero_evt  (fr_zero),
    .mode_q    (fr_mode)
);

// File: tb/sc_genlock_tx_tb_top.sv
`timescale 1ns/100ps
module sc_genlock_tx_tb_top;
    localparam int W = 23;

    typedef struct {
        logic  val;
        logic  zero;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_strobe = 1'b0;
    logic         mode_rtc = 1'b0;
    logic [W-1:0] ctrl_word = '0;
    logic         phase_rst_req = 1'b0;
    logic         ser_out;
    logic [W-1:0] dds_phase;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    logic [W-1:0] model = '0;
    bit pend = 0;
    bit mon_on = 0;

    always #2.5 clk = ~clk;

    sc_genlock_tx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_strobe   (line_strobe),
        .mode_rtc      (mode_rtc),
        .ctrl_word     (ctrl_word),
        .phase_rst_req (phase_rst_req),
        .ser_out       (ser_out),
        .dds_phase     (dds_phase)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input logic v, input logic z, input string tag, input int n);
        for (int i = 0; i < n; i++) q.push_back('{val: v, zero: (z && i == 0), tag: tag});
    endtask

    // Monitor: pop expected pin values and track the phase model.
    always @(negedge clk) begin
        if (!rst_n) begin
            model = '0;
        end else if (mon_on) begin
            exp_t e;
            if (q.size() > 0) begin
                e = q.pop_front();
                check({e.tag, " pin"}, W'(ser_out), W'(e.val));
                if (e.zero) check("R9 phase at slot", dds_phase, '0);
            end
            check("R8 phase", dds_phase, model);
            if (q.size() > 0 && q[0].zero) model = '0;
            else model = model + ctrl_word;
        end
    end

    // Driver: start one line, push its expected stream, apply mid-line stimulus.
    task automatic run_line(input logic [W-1:0] w, input logic rtc,
                            input bit mid_change, input bit extra_strobe, input bit mid_req);
        bit armed;
        @(posedge clk); #1;
        line_strobe = 1'b1; ctrl_word = w; mode_rtc = rtc;
        @(posedge clk); #1;
        line_strobe = 1'b0;
        armed = pend; pend = 0;
        if (!rtc) begin
            push(1'b1, 1'b0, "R2 start", 1);
            for (int b = W - 1; b >= 0; b--) push(w[b], 1'b0, "R3 data", 1);
            push(1'b0, 1'b0, "R4 gap", 7);
            push(!armed, armed, armed ? "R7 slot low" : "R4 slot high", 1);
        end else begin
            push(1'b1, 1'b0, "R5 start", 8);
            for (int b = W - 1; b >= 1; b--) push(w[b], 1'b0, "R5 data", 8);
            push(1'b0, 1'b0, "R6 gap", 24);
            push(!armed, armed, armed ? "R7 slot low" : "R6 slot high", 8);
        end
        push(1'b0, 1'b0, "R2 idle", 4);
        if (mid_change || extra_strobe || mid_req) begin
            repeat (6) @(posedge clk);
            #1;
            if (extra_strobe) line_strobe = 1'b1;   // R10
            if (mid_change) begin ctrl_word = ~w; mode_rtc = !rtc; end  // R11
            if (mid_req) begin phase_rst_req = 1'b1; pend = 1; end      // R7
            @(posedge clk); #1;
            line_strobe = 1'b0; phase_rst_req = 1'b0;
        end
        wait (q.size() == 0);
    endtask

    task automatic pulse_req();
        @(posedge clk); #1; phase_rst_req = 1'b1; pend = 1;
        @(posedge clk); #1; phase_rst_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 to R11 actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        ctrl_word = 23'h12_3456;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset pin", W'(ser_out), '0);
        check("R1 reset phase", dds_phase, '0);
        @(posedge clk); #1; rst_n = 1'b1; mon_on = 1;
        repeat (5) @(posedge clk);
        run_line(23'h5A_A5C3, 1'b0, 0, 0, 0);        // R3 R4
        pulse_req();
        repeat (3) @(posedge clk);
        run_line(23'h7F_0001, 1'b0, 0, 0, 0);        // R7 R9 low slot
        run_line(23'h00_0F0F, 1'b0, 0, 0, 0);        // R7 cleared
        run_line(23'h2A_AAAB, 1'b0, 0, 0, 1);        // R7 mid-line request deferred
        run_line(23'h40_0003, 1'b1, 0, 0, 0);        // R5 R6 R9 in slow framing
        run_line(23'h55_1234, 1'b1, 1, 1, 0);        // R10 R11 slow
        run_line(23'h3C_3C3C, 1'b0, 1, 1, 1);        // R10 R11 full
        run_line(23'h7F_FFFF, 1'b1, 0, 0, 0);        // R8 wrap, R7 slow low slot
        ctrl_word = 23'h7F_FFFF;
        repeat (20) @(posedge clk);                  // R8 wrap while idle
        @(negedge clk);
        check("R2 idle after frames", W'(ser_out), '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule